// File: doc/BRIEF.md
# Chip-Select External Bus Controller

This block turns requests from the internal side into cycles on an external bus. The external bus has a 21-bit address and a 16-bit shared address/data bus. The requester presents an address, a direction, a size (byte or word) and write data. It holds `reqValid` high until the block pulses `reqAck`. Read data is valid on `rdData` during that acknowledge cycle.

Three chip-select regions set the shape of each bus cycle. Each region has an inclusive address window, a wait-state count from 0 to 3, an 8- or 16-bit data width, and a multiplexed or demultiplexed address/data mode. The region is decoded again for every request, so the bus protocol can change from one access to the next.

A word access to an 8-bit region is carried out as two byte cycles. The pin next to the strobes can act as a byte-high enable or as a separate high-byte write strobe. A simple hold handshake lets an external master take the bus while no cycle is running.

Top module: `extbus_csu`

## Requirements
- R1: Region select. A request whose address lies inside [lo,hi] of region i asserts only `csN[i]` low. When ranges overlap, the lowest-numbered region wins. An address in no range asserts no chip select and uses 16-bit multiplexed mode with 3 wait states.
- R2: Wait states. Every bus cycle has one address cycle followed by a data phase of (wait+1) clocks. `rdN` or the write strobe is low during the data phase. `reqAck` rises for one clock after the last data phase.
- R3: Address phase. `ale` is high for exactly the first clock of each bus cycle. During that clock `addrHi` and `addrLo` hold the cycle address, and so do `adOut` lanes in multiplexed mode. `addrHi` and `addrLo` stay stable into the data phase.
- R4: Multiplexed data phase.
  - 16-bit reads release both lanes (`adOe`=00) and capture `adIn`.
  - 8-bit cycles keep address bits 15:8 driven on `adOut[15:8]` (`adOe[1]`=1) and move data on `adOut[7:0]`/`adIn[7:0]`.
- R5: Demultiplexed mode.
  - 16-bit writes drive the write data on `adOut` in both the address and the data clocks.
  - 8-bit cycles carry the byte on lane 0, and lane 1 drives `reqWdata[15:8]`.
- R6: Byte-high-enable mode (`hbSel`=1), 16-bit cycles. `bhewN` low with `addrLo[0]`=0 means a word. `bhewN` low with `addrLo[0]`=1 means the high byte only. `bhewN` high with `addrLo[0]`=0 means the low byte only. On 8-bit cycles `bhewN` stays high.
- R7: Strobe mode (`hbSel`=0). On writes, `wrN` strobes the low lane and `bhewN` strobes the high lane, each only for bytes actually written. `rdN` and `wrN` are never low together.
- R8: A word request to an 8-bit region runs two bus cycles: the even address first, then the odd one. The request is acknowledged once, after the second cycle, and `rdData` = {odd byte, even byte}.
- R9: Byte data sits in `reqWdata[7:0]` and `rdData[7:0]`, with `rdData[15:8]`=0. On a 16-bit region an odd address uses lane 1, so a byte read returns `adIn[15:8]`.
- R10: While no cycle runs, `holdReqN` low grants the bus (`holdAckN` low, no chip select, no `ale`). During the grant `busReqN` is low while `reqValid` is high. Raising `holdReqN` ends the grant and lets the pending request run.
- R11: `busIdle` is high when neither a bus cycle nor a hold is in progress (after reset, and in the acknowledge clock). It is low in every address and data clock and during a hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Internal request pending, held until ack |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWord | input | 1 | 1 = word (even address), 0 = byte |
| reqAddr | input | 21 | Request byte address |
| reqWdata | input | 16 | Write data (byte in bits 7:0) |
| reqAck | output | 1 | One-clock completion pulse |
| rdData | output | 16 | Read data, valid with reqAck |
| csLo | input | 63 | Per-region lower bound, region i in bits [21i+:21] |
| csHi | input | 63 | Per-region upper bound, inclusive |
| csWait | input | 6 | Per-region wait states, 2 bits each |
| csWide | input | 3 | Per-region width, 1 = 16-bit |
| csMuxed | input | 3 | Per-region mode, 1 = multiplexed |
| hbSel | input | 1 | 1 = byte-high enable, 0 = high-byte write strobe |
| holdReqN | input | 1 | External hold request, active low |
| holdAckN | output | 1 | Hold grant, active low |
| busReqN | output | 1 | Pending request during hold, active low |
| busIdle | output | 1 | No cycle or hold in progress |
| ale | output | 1 | Address latch enable |
| csN | output | 3 | Chip selects, active low |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe (low lane in strobe mode) |
| bhewN | output | 1 | Byte-high enable or high-byte write strobe |
| addrHi | output | 5 | Address bits 20:16 |
| addrLo | output | 16 | Address bits 15:0 (demultiplexed address) |
| adOut | output | 16 | Address/data bus drive value |
| adOe | output | 2 | Per-lane output enable for adOut |
| adIn | input | 16 | Address/data bus receive value |

## Verification
The hardest case to reach is the second half of a split word access to an 8-bit region. It needs a word request, an address inside a narrow window, and a memory model that returns a different byte for each address. Only then can the high/low ordering and the single acknowledge be told apart. The bench answers every read from a model that derives lane data from the address currently on `addrLo`. It records the address at each `ale` clock and checks the assembled word. Overlapping windows and hold-while-pending are set up by placing two regions over a shared range and by raising `reqValid` while the grant is active.

// File: rtl/extbus_pkg.sv
package extbus_pkg;
  localparam int ADDR_W = 21;
  localparam int DATA_W = 16;
  localparam int NUM_CS = 3;
  localparam int WAIT_W = 2;

  typedef struct packed {
    logic load;     // latch the accepted request
    logic addrPh;   // address clock of a bus cycle
    logic dataPh;   // data phase clock
    logic capture;  // last data clock: sample read data
    logic part;     // second byte of a split word
  } busStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_ACK,
    ST_HOLD
  } busState_t;
endpackage

// File: rtl/extbus_ctrl.sv
module extbus_ctrl
  import extbus_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NCS = NUM_CS,
  parameter int WW = WAIT_W,
  parameter logic [WAIT_W-1:0] DEF_WAIT = 2'd3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWord,
  input  logic [AW-1:0]    reqAddr,
  input  logic [NCS*AW-1:0] csLo,
  input  logic [NCS*AW-1:0] csHi,
  input  logic [NCS*WW-1:0] csWait,
  input  logic [NCS-1:0]   csWide,
  input  logic [NCS-1:0]   csMuxed,
  input  logic             holdReqN,
  output busStrobe_t       strobe,
  output logic             regWide,
  output logic             regMuxed,
  output logic             ale,
  output logic [NCS-1:0]   csN,
  output logic             holdAckN,
  output logic             busReqN,
  output logic             busIdle,
  output logic             reqAck
);
  busState_t state;
  logic [NCS-1:0] hit;
  logic [NCS-1:0] selOneHot, regOneHot;
  logic [WW-1:0]  selWait, regWait, waitCnt;
  logic           selWide, selMuxed;
  logic           splitReg, partReg;

  genvar g;
  generate
    for (g = 0; g < NCS; g++) begin : g_hit
      assign hit[g] = (reqAddr >= csLo[g*AW +: AW]) && (reqAddr <= csHi[g*AW +: AW]);
    end
  endgenerate

  // lowest index wins: scan from the top so lower indices overwrite
  always_comb begin
    selOneHot = '0;
    selWait   = DEF_WAIT;
    selWide   = 1'b1;
    selMuxed  = 1'b1;
    for (int i = NCS-1; i >= 0; i--) begin
      if (hit[i]) begin
        selOneHot    = '0;
        selOneHot[i] = 1'b1;
        selWait      = csWait[i*WW +: WW];
        selWide      = csWide[i];
        selMuxed     = csMuxed[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      regOneHot <= '0;
      regWait   <= '0;
      regWide   <= 1'b1;
      regMuxed  <= 1'b1;
      splitReg  <= 1'b0;
      partReg   <= 1'b0;
      waitCnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (!holdReqN) begin
            state <= ST_HOLD;
          end else if (reqValid) begin
            state     <= ST_ADDR;
            regOneHot <= selOneHot;
            regWait   <= selWait;
            regWide   <= selWide;
            regMuxed  <= selMuxed;
            splitReg  <= reqWord && !selWide;
            partReg   <= 1'b0;
          end
        end
        ST_ADDR: begin
          waitCnt <= regWait;
          state   <= ST_DATA;
        end
        ST_DATA: begin
          if (waitCnt != '0) begin
            waitCnt <= waitCnt - 1'b1;
          end else if (splitReg && !partReg) begin
            partReg <= 1'b1;
            state   <= ST_ADDR;
          end else begin
            state <= ST_ACK;
          end
        end
        ST_ACK:  state <= ST_IDLE;
        ST_HOLD: if (holdReqN) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load    = (state == ST_IDLE) && holdReqN && reqValid;
    strobe.addrPh  = (state == ST_ADDR);
    strobe.dataPh  = (state == ST_DATA);
    strobe.capture = (state == ST_DATA) && (waitCnt == '0);
    strobe.part    = partReg;
  end

  assign ale      = (state == ST_ADDR);
  assign csN      = ((state == ST_ADDR) || (state == ST_DATA)) ? ~regOneHot : '1;
  assign holdAckN = !(state == ST_HOLD);
  assign busReqN  = !((state == ST_HOLD) && reqValid);
  assign busIdle  = (state == ST_IDLE) || (state == ST_ACK);
  assign reqAck   = (state == ST_ACK);

  // R1: at most one chip select low at any time
  assert_cs_onehot_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));
  // R3: ALE lasts a single clock
  assert_ale_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale);
  // R8: one acknowledge per request
  assert_ack_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);
  // R10: while the bus is granted, no chip select and no ALE
  assert_hold_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !holdAckN |-> (csN == '1) && !ale);
  // R10: bus request only appears under a grant
  assert_busreq_grant_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busReqN |-> !holdAckN);
endmodule

// File: rtl/extbus_dpath.sv
module extbus_dpath
  import extbus_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  busStrobe_t      strobe,
  input  logic            regWide,
  input  logic            regMuxed,
  input  logic            hbSel,
  input  logic [AW-1:0]   reqAddr,
  input  logic            reqWord,
  input  logic            reqWrite,
  input  logic [DW-1:0]   reqWdata,
  input  logic [DW-1:0]   adIn,
  output logic [AW-DW-1:0] addrHi,
  output logic [DW-1:0]   addrLo,
  output logic [DW-1:0]   adOut,
  output logic [1:0]      adOe,
  output logic            rdN,
  output logic            wrN,
  output logic            bhewN,
  output logic [DW-1:0]   rdData
);
  localparam int LW = DW / 2;

  logic [AW-1:0] aReg;
  logic [DW-1:0] wdReg;
  logic          wordReg, writeReg;
  logic [AW-1:0] curAddr;
  logic          active, loUse, hiUse;
  logic [LW-1:0] lane0Val, lane1Val;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg     <= '0;
      wdReg    <= '0;
      wordReg  <= 1'b0;
      writeReg <= 1'b0;
      rdData   <= '0;
    end else if (strobe.load) begin
      aReg     <= reqAddr;
      wdReg    <= reqWdata;
      wordReg  <= reqWord;
      writeReg <= reqWrite;
      rdData   <= '0;
    end else if (strobe.capture && !writeReg) begin
      if (regWide) begin
        if (wordReg)         rdData <= adIn;
        else if (curAddr[0]) rdData <= {{LW{1'b0}}, adIn[DW-1:LW]};
        else                 rdData <= {{LW{1'b0}}, adIn[LW-1:0]};
      end else if (strobe.part) begin
        rdData[DW-1:LW] <= adIn[LW-1:0];
      end else begin
        rdData[LW-1:0] <= adIn[LW-1:0];
      end
    end
  end

  assign curAddr = {aReg[AW-1:1], aReg[0] | strobe.part};
  assign active  = strobe.addrPh || strobe.dataPh;
  assign addrHi  = active ? curAddr[AW-1:DW] : '0;
  assign addrLo  = active ? curAddr[DW-1:0] : '0;

  always_comb begin
    if (regWide) begin
      loUse    = wordReg || !curAddr[0];
      hiUse    = wordReg || curAddr[0];
      lane0Val = wdReg[LW-1:0];
      lane1Val = wordReg ? wdReg[DW-1:LW] : wdReg[LW-1:0];
    end else begin
      loUse    = 1'b1;
      hiUse    = 1'b0;
      lane0Val = strobe.part ? wdReg[DW-1:LW] : wdReg[LW-1:0];
      lane1Val = regMuxed ? curAddr[DW-1:LW] : wdReg[DW-1:LW];
    end
  end

  always_comb begin
    adOut = '0;
    adOe  = 2'b00;
    if (strobe.addrPh && regMuxed) begin
      adOut = curAddr[DW-1:0];
      adOe  = 2'b11;
    end else if (active) begin
      adOut = {lane1Val, lane0Val};
      adOe  = writeReg ? 2'b11 : (regWide ? 2'b00 : 2'b10);
    end
  end

  always_comb begin
    rdN = !(strobe.dataPh && !writeReg);
    if (hbSel) begin
      wrN   = !(strobe.dataPh && writeReg);
      bhewN = !(active && regWide && hiUse);
    end else begin
      wrN   = !(strobe.dataPh && writeReg && loUse);
      bhewN = !(strobe.dataPh && writeReg && regWide && hiUse);
    end
  end

  // R3: the address set up under ALE is held into the data phase
  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.addrPh |=> $stable(addrHi) && $stable(addrLo));
  // R3: a read strobe only starts right after an address clock
  assert_rd_after_ale_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdN) |-> $past(strobe.addrPh));
  // R7: read and write strobes are exclusive
  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));
endmodule

// File: rtl/extbus_csu.sv
module extbus_csu
  import extbus_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int DW  = DATA_W,
  parameter int NCS = NUM_CS,
  parameter int WW  = WAIT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqWord,
  input  logic [AW-1:0]     reqAddr,
  input  logic [DW-1:0]     reqWdata,
  output logic              reqAck,
  output logic [DW-1:0]     rdData,
  input  logic [NCS*AW-1:0] csLo,
  input  logic [NCS*AW-1:0] csHi,
  input  logic [NCS*WW-1:0] csWait,
  input  logic [NCS-1:0]    csWide,
  input  logic [NCS-1:0]    csMuxed,
  input  logic              hbSel,
  input  logic              holdReqN,
  output logic              holdAckN,
  output logic              busReqN,
  output logic              busIdle,
  output logic              ale,
  output logic [NCS-1:0]    csN,
  output logic              rdN,
  output logic              wrN,
  output logic              bhewN,
  output logic [AW-DW-1:0]  addrHi,
  output logic [DW-1:0]     addrLo,
  output logic [DW-1:0]     adOut,
  output logic [1:0]        adOe,
  input  logic [DW-1:0]     adIn
);
  busStrobe_t strobe;
  logic regWide, regMuxed;

  extbus_ctrl #(.AW(AW), .NCS(NCS), .WW(WW)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWord(reqWord),
    .reqAddr(reqAddr), .csLo(csLo), .csHi(csHi), .csWait(csWait),
    .csWide(csWide), .csMuxed(csMuxed), .holdReqN(holdReqN),
    .strobe(strobe), .regWide(regWide), .regMuxed(regMuxed), .ale(ale),
    .csN(csN), .holdAckN(holdAckN), .busReqN(busReqN), .busIdle(busIdle),
    .reqAck(reqAck)
  );

  extbus_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWide(regWide),
    .regMuxed(regMuxed), .hbSel(hbSel), .reqAddr(reqAddr), .reqWord(reqWord),
    .reqWrite(reqWrite), .reqWdata(reqWdata), .adIn(adIn), .addrHi(addrHi),
    .addrLo(addrLo), .adOut(adOut), .adOe(adOe), .rdN(rdN), .wrN(wrN),
    .bhewN(bhewN), .rdData(rdData)
  );
endmodule

// File: tb/extbus_csu_tb.sv
module extbus_csu_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqWord = 1'b0;
  logic [20:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic reqAck;
  logic [15:0] rdData;
  logic [62:0] csLo, csHi;
  logic [5:0]  csWait;
  logic [2:0]  csWide, csMuxed;
  logic hbSel = 1'b1;
  logic holdReqN = 1'b1;
  logic holdAckN, busReqN, busIdle, ale, rdN, wrN, bhewN;
  logic [2:0] csN;
  logic [4:0] addrHi;
  logic [15:0] addrLo, adOut, adIn;
  logic [1:0] adOe;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  // region 0: 16-bit demux, 0 waits; region 1: 8-bit mux, 1 wait;
  // region 2: 8-bit demux, 2 waits, overlapping region 1
  assign csLo    = {21'h02800, 21'h02000, 21'h01000};
  assign csHi    = {21'h04FFF, 21'h02FFF, 21'h01FFF};
  assign csWait  = {2'd2, 2'd1, 2'd0};
  assign csWide  = 3'b001;
  assign csMuxed = 3'b010;

  // memory model: lane data derived from the current address
  assign adIn = {addrLo[7:0] ^ 8'hC3, addrLo[7:0] ^ 8'h5A};

  extbus_csu u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqWord(reqWord), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqAck(reqAck), .rdData(rdData), .csLo(csLo), .csHi(csHi),
    .csWait(csWait), .csWide(csWide), .csMuxed(csMuxed), .hbSel(hbSel),
    .holdReqN(holdReqN), .holdAckN(holdAckN), .busReqN(busReqN),
    .busIdle(busIdle), .ale(ale), .csN(csN), .rdN(rdN), .wrN(wrN),
    .bhewN(bhewN), .addrHi(addrHi), .addrLo(addrLo), .adOut(adOut),
    .adOe(adOe), .adIn(adIn)
  );

  // per-access observations
  int nAle, nStrobe, nBusy;
  logic [2:0]  cs1;
  logic [15:0] aleAd1, aleLo1, aleLo2, firstAd, lastAd, rdAck;
  logic [4:0]  aleHi1;
  logic [1:0]  lastOe;
  logic        lastBhew, wrLow, hiLow, anyBheLow, ackAgain, wdOk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runAccess(input logic [20:0] a, input logic w, input logic wd,
                           input logic [15:0] d);
    nAle = 0; nStrobe = 0; nBusy = 0; wrLow = 0; hiLow = 0; anyBheLow = 0;
    cs1 = '1; aleAd1 = '0; aleLo1 = '0; aleLo2 = '0; aleHi1 = '0;
    firstAd = '0; lastAd = '0; lastOe = '0; lastBhew = 1'b1; wdOk = 1'b0;
    @(negedge clk);
    reqAddr = a; reqWrite = w; reqWord = wd; reqWdata = d; reqValid = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (reqAck) begin
        wdOk = 1'b1;
        break;
      end
      if (!busIdle) nBusy++;
      if (!bhewN) anyBheLow = 1'b1;
      if (ale) begin
        nAle++;
        if (nAle == 1) begin
          aleAd1 = adOut; aleLo1 = addrLo; aleHi1 = addrHi; cs1 = csN;
        end else begin
          aleLo2 = addrLo;
        end
      end
      if (!rdN || !wrN || (!hbSel && !bhewN)) begin
        nStrobe++;
        if (nStrobe == 1) firstAd = adOut;
        lastAd = adOut; lastOe = adOe; lastBhew = bhewN;
        if (!wrN) wrLow = 1'b1;
        if (!bhewN) hiLow = 1'b1;
      end
    end
    rdAck = rdData;
    reqValid = 1'b0;
    @(negedge clk);
    ackAgain = reqAck;
    check("R2 ack reached", {31'd0, wdOk}, 32'd1);
  endtask

  task automatic testReset();
    check("R11 reset busIdle", {31'd0, busIdle}, 32'd1);
    check("R1 reset csN", {29'd0, csN}, 32'h7);
    check("R3 reset ale", {31'd0, ale}, 32'd0);
    check("R2 reset strobes", {29'd0, rdN, wrN, bhewN}, 32'h7);
    check("R10 reset holdAckN", {31'd0, holdAckN}, 32'd1);
    check("R2 reset reqAck", {31'd0, reqAck}, 32'd0);
  endtask

  task automatic testDefaultMux16Read();
    runAccess(21'h10AB4, 1'b0, 1'b1, 16'h0);
    check("R1 default no cs", {29'd0, cs1}, 32'h7);
    check("R2 default 3 waits", nStrobe, 4);
    check("R3 one ale", nAle, 1);
    check("R3 mux address on AD", aleAd1, 32'h0AB4);
    check("R3 upper address", aleHi1, 32'h01);
    check("R4 mux16 read releases lanes", lastOe, 32'd0);
    check("R4 mux16 read data", rdAck, 32'h77EE);
    check("R6 word bhe low", lastBhew, 32'd0);
    check("R11 busy during cycle", nBusy, 5);
  endtask

  task automatic testDemux16Write();
    runAccess(21'h01234, 1'b1, 1'b1, 16'hBEEF);
    check("R1 region0 cs", {29'd0, cs1}, 32'h6);
    check("R2 zero waits", nStrobe, 1);
    check("R5 demux16 data in address clock", aleAd1, 32'hBEEF);
    check("R5 demux16 data in data clock", lastAd, 32'hBEEF);
    check("R3 demux address pins", aleLo1, 32'h1234);
  endtask

  task automatic testSplitRead8();
    runAccess(21'h02010, 1'b0, 1'b1, 16'h0);
    check("R1 region1 cs", {29'd0, cs1}, 32'h5);
    check("R8 two bus cycles", nAle, 2);
    check("R2 one wait each", nStrobe, 4);
    check("R8 even address first", aleLo1, 32'h2010);
    check("R8 odd address second", aleLo2, 32'h2011);
    check("R8 assembled word", rdAck, 32'h4B4A);
    check("R8 single ack", {31'd0, ackAgain}, 32'd0);
    check("R4 mux8 high lane holds address", lastAd[15:8], 32'h20);
    check("R4 mux8 read lane enables", lastOe, 32'h2);
    check("R6 narrow bhe inactive", {31'd0, anyBheLow}, 32'd0);
  endtask

  task automatic testOverlapPriority();
    runAccess(21'h02900, 1'b0, 1'b0, 16'h0);
    check("R1 overlap lowest wins", {29'd0, cs1}, 32'h5);
    check("R9 byte read narrow", rdAck, 32'h005A);
    check("R2 region1 byte wait", nStrobe, 2);
  endtask

  task automatic testDemux8Write();
    runAccess(21'h03456, 1'b1, 1'b1, 16'hA55A);
    check("R1 region2 cs", {29'd0, cs1}, 32'h3);
    check("R2 two waits each", nStrobe, 6);
    check("R5 demux8 first byte", firstAd, 32'hA55A);
    check("R5 demux8 second byte", lastAd, 32'hA5A5);
  endtask

  task automatic testBheMode();
    hbSel = 1'b1;
    runAccess(21'h01001, 1'b1, 1'b0, 16'h0033);
    check("R6 odd byte bhe low", lastBhew, 32'd0);
    check("R6 odd byte A0", aleLo1[0], 32'd1);
    check("R9 odd byte on high lane", lastAd[15:8], 32'h33);
    check("R2 write strobe", {31'd0, wrLow}, 32'd1);
    runAccess(21'h01000, 1'b1, 1'b0, 16'h0044);
    check("R6 even byte bhe high", lastBhew, 32'd1);
    check("R9 even byte on low lane", lastAd[7:0], 32'h44);
  endtask

  task automatic testStrobeMode();
    hbSel = 1'b0;
    runAccess(21'h01001, 1'b1, 1'b0, 16'h0011);
    check("R7 odd byte no low strobe", {31'd0, wrLow}, 32'd0);
    check("R7 odd byte high strobe", {31'd0, hiLow}, 32'd1);
    runAccess(21'h01002, 1'b1, 1'b0, 16'h0022);
    check("R7 even byte low strobe", {31'd0, wrLow}, 32'd1);
    check("R7 even byte no high strobe", {31'd0, hiLow}, 32'd0);
    runAccess(21'h01004, 1'b1, 1'b1, 16'h1234);
    check("R7 word both strobes", {30'd0, wrLow, hiLow}, 32'h3);
    hbSel = 1'b1;
  endtask

  task automatic testOddRead16();
    runAccess(21'h01235, 1'b0, 1'b0, 16'h0);
    check("R9 odd byte read", rdAck, 32'h00F6);
  endtask

  task automatic testHold();
    int n;
    @(negedge clk);
    holdReqN = 1'b0;
    @(negedge clk);
    check("R10 grant", {31'd0, holdAckN}, 32'd0);
    check("R10 no request yet", {31'd0, busReqN}, 32'd1);
    check("R11 idle low in hold", {31'd0, busIdle}, 32'd0);
    reqAddr = 21'h01100; reqWrite = 1'b0; reqWord = 1'b1; reqValid = 1'b1;
    @(negedge clk);
    check("R10 bus request while pending", {31'd0, busReqN}, 32'd0);
    check("R10 no cycle in hold", {28'd0, ale, csN}, 32'h7);
    holdReqN = 1'b1;
    n = 0;
    while (!reqAck && n < 40) begin
      @(negedge clk);
      n++;
    end
    check("R10 pending request completes", {31'd0, reqAck}, 32'd1);
    check("R10 released grant", {31'd0, holdAckN}, 32'd1);
    reqValid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testDefaultMux16Read();
    testDemux16Write();
    testSplitRead8();
    testOverlapPriority();
    testDemux8Write();
    testBheMode();
    testStrobeMode();
    testOddRead16();
    testHold();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule